// File: doc/BRIEF.md
# Ping-Pong Audio Playback DMA

This engine plays audio by reading samples from memory and handing them, one at a time, to a codec sample port. Two playback buffers sit at fixed distances above one programmable base address: the first begins 0x10000 bytes above the base and the second begins 0x12000 bytes above it. Once started, the engine walks the first buffer from byte position 0 up to the programmed buffer size. It then marks that buffer as drained, moves to the other buffer at position 0, and keeps alternating between the two until software stops it. While one buffer plays, software refills the other. The drained marks drive an interrupt line that feeds the chip's DMA interrupt path.

Software reaches the engine through a byte-wide register port. The 32-bit base is loaded one byte at a time, with the lowest offset holding the most significant byte. The 16-bit size is loaded as a high byte and a low byte. A control byte starts and stops playback, and the same byte can request that the pending codec settings be loaded into the codec. A second byte offset acknowledges drained marks. Memory reads use a request/grant pair followed by a read-valid return. Samples leave on a valid/ready stream.

Top module: `snd_pingpong_dma`

## Requirements
- R1: After reset the base, size, drained marks, buffer select and run bit are all zero, reg_rdata reads 0 at every offset, and mem_req, smp_valid, dma_irq and codec_load are low.
- R2: A write to offset 0, 1, 2 or 3 replaces base byte [31:24], [23:16], [15:8] or [7:0] respectively. A write to offset 4 or 5 replaces size byte [15:8] or [7:0]. Each of these bytes reads back at the offset it was written to, starting the cycle after the write.
- R3: Each sample takes one memory read, at byte address base + 0x10000 + position for buffer 0 or base + 0x12000 + position for buffer 1 (modulo 2^32). The position advances by 2 each time a sample is accepted, and the returned word appears on smp_data.
- R4: When the sample accepted at position p satisfies p + 2 >= size, the drained mark of the active buffer is set in the next cycle, the buffer select toggles and the position returns to 0. Offset 8 reads {drained1, drained0, 3'b000, buffer select, 1'b0, run} (drained1 in bit 7, drained0 in bit 6).
- R5: Writing offset 8 with bit 0 set while stopped starts playback at buffer 0, position 0. The same write while running does not restart playback.
- R6: Writing offset 8 with bit 0 clear stops playback. While stopped, mem_req and smp_valid stay low.
- R7: dma_irq is high exactly while at least one drained mark is set.
- R8: A write to offset 9 clears drained1 when bit 7 is 1 and drained0 when bit 6 is 1 (0xF0 clears both). Bits 3:0 have no effect. A mark being set in the same cycle wins over its clear.
- R9: A write to offset 8 whose bits 7 and 6 are both 1 pulses codec_load high for exactly the next cycle.
- R10: A mem_req waiting for mem_gnt holds its address, and a smp_valid waiting for smp_ready holds its data, until accepted, unless a register write intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational on reg_addr) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory byte address |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| smp_valid | output | 1 | Sample available |
| smp_data | output | DW | Sample word |
| smp_ready | input | 1 | Codec takes the sample |
| codec_load | output | 1 | One-cycle request to load the codec settings |
| dma_irq | output | 1 | Drained interrupt toward the DMA interrupt flag path |

## Verification
Register bytes, the status byte, the run bit, the drained marks and dma_irq all change in the cycle after the edge that takes the write or the final sample handshake. codec_load is high only in the cycle after the edge that takes its write. mem_addr and reg_rdata follow the registers combinationally in the same cycle. The bench drives inputs just after the rising edge and checks at the falling edge. Before the next edge, its model applies whatever that edge will take: a handshake, a write or a clear. Each comparison therefore meets the design one register stage later, exactly where the requirements place the change.

// File: rtl/snd_pingpong_dma.sv
module snd_pingpong_dma #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int DW = 16,
  parameter logic [31:0] BUF0_OFS = 32'h0001_0000,
  parameter logic [31:0] BUF1_OFS = 32'h0001_2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  input  logic          smp_ready,
  output logic          codec_load,
  output logic          dma_irq
);
  localparam int NB = AW / 8;
  localparam int SB = DW / 8;
  localparam logic [3:0] A_SZ_HI = 4'd4;
  localparam logic [3:0] A_SZ_LO = 4'd5;
  localparam logic [3:0] A_CTRL  = 4'd8;
  localparam logic [3:0] A_ACK   = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} st_t;

  st_t           st_q;
  logic [AW-1:0] base_q;
  logic [SW-1:0] size_q, pos_q;
  logic [DW-1:0] data_q;
  logic [1:0]    flag_q, flag_nxt, set_v, clr_v;
  logic          buf_q, run_q, load_q, irq_q;

  wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  wire wr_ack  = reg_wr && (reg_addr == A_ACK);
  wire start   = wr_ctrl && reg_wdata[0] && !run_q;
  wire stop    = wr_ctrl && !reg_wdata[0];
  wire take    = (st_q == ST_OUT) && smp_ready && !stop;

  wire [SW:0] pos_nxt = {1'b0, pos_q} + (SW+1)'(SB);
  wire        last    = pos_nxt >= {1'b0, size_q};

  assign set_v    = (take && last) ? (buf_q ? 2'b10 : 2'b01) : 2'b00;
  assign clr_v    = wr_ack ? reg_wdata[7:6] : 2'b00;
  assign flag_nxt = (flag_q & ~clr_v) | set_v;

  assign mem_req    = (st_q == ST_REQ);
  assign mem_addr   = base_q + AW'(buf_q ? BUF1_OFS : BUF0_OFS) + AW'(pos_q);
  assign smp_valid  = (st_q == ST_OUT);
  assign smp_data   = data_q;
  assign codec_load = load_q;
  assign dma_irq    = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NB; i++)
        if (reg_addr == 4'(i)) base_q[AW-1-8*i -: 8] <= reg_wdata;
      if (reg_addr == A_SZ_HI) size_q[SW-1 -: 8] <= reg_wdata;
      if (reg_addr == A_SZ_LO) size_q[7:0] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      run_q  <= 1'b0;
      buf_q  <= 1'b0;
      pos_q  <= '0;
      data_q <= '0;
    end else if (stop) begin
      st_q  <= ST_IDLE;
      run_q <= 1'b0;
    end else if (start) begin
      st_q  <= ST_REQ;
      run_q <= 1'b1;
      buf_q <= 1'b0;
      pos_q <= '0;
    end else begin
      case (st_q)
        ST_REQ:  if (mem_gnt) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          st_q   <= ST_OUT;
        end
        ST_OUT: if (take) begin
          st_q <= ST_REQ;
          if (last) begin
            pos_q <= '0;
            buf_q <= ~buf_q;
          end else begin
            pos_q <= pos_nxt[SW-1:0];
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= |flag_nxt;
      load_q <= wr_ctrl && (reg_wdata[7:6] == 2'b11);
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NB; i++)
      if (reg_addr == 4'(i)) reg_rdata = base_q[AW-1-8*i -: 8];
    case (reg_addr)
      A_SZ_HI: reg_rdata = size_q[SW-1 -: 8];
      A_SZ_LO: reg_rdata = size_q[7:0];
      A_CTRL:  reg_rdata = {flag_q[1], flag_q[0], 3'b000, buf_q, 1'b0, run_q};
      default: ;
    endcase
  end
endmodule

module snd_pingpong_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          smp_ready,
  input logic          codec_load,
  input logic          dma_irq,
  input logic          run_q,
  input logic [1:0]    flag_q
);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!mem_req && !smp_valid));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !reg_wr) |=> (mem_req && $stable(mem_addr)));

  a_r10_smp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !reg_wr) |=> (smp_valid && $stable(smp_data)));

  a_r9_load_src: assert property (@(posedge clk) disable iff (!rst_n)
    codec_load |-> $past(reg_wr && reg_addr == 4'd8 && reg_wdata[7:6] == 2'b11));

  a_r4_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q[0]) || $rose(flag_q[1])) |-> $past(smp_valid && smp_ready));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq == (flag_q != 2'b00));
endmodule

bind snd_pingpong_dma snd_pingpong_dma_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_gnt(mem_gnt), .smp_valid(smp_valid), .smp_data(smp_data),
  .smp_ready(smp_ready), .codec_load(codec_load), .dma_irq(dma_irq),
  .run_q(run_q), .flag_q(flag_q)
);

// File: tb/snd_pingpong_dma_tb.sv
module snd_pingpong_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd8;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic mem_req, mem_gnt, smp_valid, smp_ready, codec_load, dma_irq;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic [15:0] smp_data;
  logic stall = 1'b0;
  logic [2:0] gcnt = 3'd0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  snd_pingpong_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .codec_load(codec_load), .dma_irq(dma_irq)
  );

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  assign mem_gnt   = !stall || (gcnt[1:0] != 2'b00);
  assign smp_ready = !stall || (gcnt[2] ^ gcnt[0]);

  always @(posedge clk) begin
    gcnt       <= gcnt + 3'd1;
    mem_rvalid <= mem_req && mem_gnt;
    mem_rdata  <= memf(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_base;
  logic [15:0] m_size;
  int m_pos;
  bit m_buf, m_en, m_xp;
  logic [1:0] m_flag;

  function automatic logic [31:0] m_addr();
    return m_base + (m_buf ? 32'h12000 : 32'h10000) + 32'(m_pos);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_size = 0; m_pos = 0; m_buf = 0; m_en = 0; m_xp = 0; m_flag = 0;
    end else begin
      bit stopw, takew;
      logic [1:0] setv, clrv;
      chk(dma_irq == (m_flag != 0), "R7 irq", 32'(dma_irq), 32'(m_flag != 0));
      chk(codec_load == m_xp, "R9 codec_load", 32'(codec_load), 32'(m_xp));
      if (!m_en) chk(!mem_req && !smp_valid, "R6 idle", {mem_req, smp_valid}, 0);
      if (mem_req) chk(mem_addr == m_addr(), "R3 addr", mem_addr, m_addr());
      if (smp_valid) chk(smp_data == memf(m_addr()), "R3 data", 32'(smp_data), 32'(memf(m_addr())));
      case (reg_addr)
        4'd0, 4'd1, 4'd2, 4'd3: begin
          logic [7:0] e;
          e = m_base[31-8*reg_addr -: 8];
          chk(reg_rdata == e, "R2 base rd", 32'(reg_rdata), 32'(e));
        end
        4'd4: chk(reg_rdata == m_size[15:8], "R2 size hi", 32'(reg_rdata), 32'(m_size[15:8]));
        4'd5: chk(reg_rdata == m_size[7:0], "R2 size lo", 32'(reg_rdata), 32'(m_size[7:0]));
        4'd8: chk(reg_rdata == {m_flag, 3'b000, m_buf, 1'b0, m_en}, "R4 R8 status",
                  32'(reg_rdata), 32'({m_flag, 3'b000, m_buf, 1'b0, m_en}));
        default: ;
      endcase
      stopw = reg_wr && reg_addr == 4'd8 && !reg_wdata[0];
      takew = smp_valid && smp_ready && !stopw;
      setv = 2'b00;
      if (takew) begin
        if (m_pos + 2 >= int'(m_size)) begin
          setv = m_buf ? 2'b10 : 2'b01;
          m_buf = !m_buf;
          m_pos = 0;
        end else m_pos = m_pos + 2;
      end
      clrv = (reg_wr && reg_addr == 4'd9) ? reg_wdata[7:6] : 2'b00;
      m_flag = (m_flag & ~clrv) | setv;
      m_xp = reg_wr && reg_addr == 4'd8 && reg_wdata[7:6] == 2'b11;
      if (reg_wr) begin
        if (reg_addr <= 4'd3) m_base[31-8*reg_addr -: 8] = reg_wdata;
        if (reg_addr == 4'd4) m_size[15:8] = reg_wdata;
        if (reg_addr == 4'd5) m_size[7:0] = reg_wdata;
        if (reg_addr == 4'd8) begin
          if (!reg_wdata[0]) m_en = 0;
          else if (!m_en) begin m_en = 1; m_buf = 0; m_pos = 0; end
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 4'd8;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == e, req, 32'(reg_rdata), 32'(e));
    #1 reg_addr = 4'd8;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !smp_valid && !dma_irq && !codec_load, "R1 outputs",
        {mem_req, smp_valid, dma_irq, codec_load}, 0);
    chk(reg_rdata == 8'h00, "R1 status", 32'(reg_rdata), 0);
    rd(4'd2, 8'h00, "R1 base");
    rd(4'd5, 8'h00, "R1 size");

    // R2 byte loads, most significant byte at offset 0
    wr(4'd0, 8'h12); wr(4'd1, 8'h34); wr(4'd2, 8'h56); wr(4'd3, 8'h00);
    wr(4'd4, 8'h00); wr(4'd5, 8'h08);
    rd(4'd0, 8'h12, "R2 base msb");
    rd(4'd3, 8'h00, "R2 base lsb");
    rd(4'd1, 8'h34, "R2 base b2");
    rd(4'd5, 8'h08, "R2 size lo");

    // R3 R4 R5 playback without stalls
    wr(4'd8, 8'h01);
    @(negedge clk);
    chk(mem_req && mem_addr == 32'h1235_5600, "R5 first addr", mem_addr, 32'h1235_5600);
    repeat (150) @(posedge clk);

    // R6 stop, then R8 clears
    wr(4'd8, 8'h00);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'b11, "R4 both drained", 32'(reg_rdata[7:6]), 3);
    wr(4'd9, 8'h0F);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'b11, "R8 low nibble ignored", 32'(reg_rdata[7:6]), 3);
    wr(4'd9, 8'h40);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'b10, "R8 clear buf0", 32'(reg_rdata[7:6]), 2);
    chk(dma_irq, "R7 irq still high", 32'(dma_irq), 1);
    wr(4'd9, 8'hF0);
    @(negedge clk);
    chk(reg_rdata[7:6] == 2'b00 && !dma_irq, "R8 clear all", {reg_rdata[7:6], dma_irq}, 0);

    // R9 codec load pulse
    wr(4'd8, 8'hC0);
    @(negedge clk);
    chk(codec_load, "R9 pulse", 32'(codec_load), 1);
    @(negedge clk);
    chk(!codec_load, "R9 single cycle", 32'(codec_load), 0);

    // R5 R10 restart under stalls
    @(posedge clk); #1 stall = 1'b1;
    wr(4'd8, 8'h01);
    @(negedge clk);
    chk(mem_req && mem_addr == 32'h1235_5600, "R5 restart buf0 pos0", mem_addr, 32'h1235_5600);
    repeat (250) @(posedge clk);
    wr(4'd8, 8'hC1);
    @(negedge clk);
    chk(codec_load && reg_rdata[0], "R5 R9 running load", {codec_load, reg_rdata[0]}, 3);
    repeat (100) @(posedge clk);

    // R4 odd size: every sample drains a buffer
    wr(4'd5, 8'h01);
    repeat (120) @(posedge clk);
    wr(4'd8, 8'h00);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!mem_req && !smp_valid, "R6 stopped", {mem_req, smp_valid}, 0);
    finish_run();
  end
endmodule